// File: doc/BRIEF.md
# Clock Synthesizer Control and Power-of-Two Post-Divider

This block is the digital side of a PLL-based system clock generator. A small control register holds a feedback multiplier code, a post-divider code, two loss-of-clock enables and a clock-output disable bit. From the PLL output clock it derives a system clock divided by a power of two, and it drives a gated copy of that clock to an output pin. The analog PLL, the oscillator and the loss-of-clock detector stay outside. Three inputs stand in for them: the PLL clock itself, a raw lock flag and a loss-of-clock status flag.

The block reports lock only when the raw lock flag is set, the PLL is not stopped and no relock window is running. Writing a new multiplier code opens a fixed relock window. It does so only when the multiplier is in use, which means neither the 1:1 mode nor the external clock mode is selected. A new post-divider code is staged only while lock is reported. A code written while unlocked waits until lock returns. A staged code reaches the divider only at a point where the current system clock has just fallen, so no short pulse appears on the output and the PLL keeps its lock.

Top module: `clksyn_postdiv`

## Requirements
- R1: After reset, `rdData` reads 0x011. That is post-divider code 1 in bits 2:0, multiplier code 2 in bits 5:3, and zero in bit 6 (loss-of-clock enable), bit 7 (loss-of-clock reset enable) and bit 8 (output disable). The system clock runs at half the PLL clock rate, `resetReq` is low, and `lockOut` follows `pllLockIn`.
- R2: With post-divider code c (0..7) active, `sysClk` has a period of exactly 2^c PLL clock periods. Code 0 passes the PLL clock straight through.
- R3: When the active post-divider code switches between any two codes, no high or low phase of `sysClk` is shorter than half a PLL clock period.
- R4: A write that changes bits 5:3 in normal mode drops `lockOut` from the next cycle. `lockOut` stays low for RELOCK_CYCLES clock edges and then follows `pllLockIn` again. A write that leaves bits 5:3 unchanged does not drop lock.
- R5: In normal mode, `multFactor` equals 2*(code+2) for multiplier code `code`. In 1:1 mode and in external clock mode it equals 1.
- R6: In 1:1 mode (`oneToOneMode`=1) or external clock mode (`extClkMode`=1), a write that changes the multiplier code leaves `lockOut` high.
- R7: A post-divider code written while `lockOut` is low does not change the `sysClk` period. It takes effect once lock returns.
- R8: While `pllStopOff` is high, `lockOut` is low. After `pllStopOff` falls, `lockOut` stays low for RELOCK_CYCLES more clock edges.
- R9: `resetReq` rises one cycle after bits 6 and 7 are both set, `locStatus` is high and `extClkMode` is low. It never rises while bit 6 is clear or `extClkMode` is high. Once set, it stays high until `rstN` is applied.
- R10: While bit 8 is set, `clkOut` stays low. While bit 8 is clear, `clkOut` toggles with `sysClk`.
- R11: `rdData` returns the last value written to every field, including a post-divider code that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pllClk | input | 1 | PLL output clock; clocks the register port and the divider |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 9 | Register write value |
| rdData | output | 9 | Register read value |
| extClkMode | input | 1 | External clock mode select |
| oneToOneMode | input | 1 | 1:1 PLL mode select |
| pllLockIn | input | 1 | Raw lock flag from the PLL |
| pllStopOff | input | 1 | PLL disabled in stop mode |
| locStatus | input | 1 | Loss-of-clock status flag |
| lockOut | output | 1 | Qualified lock status |
| multFactor | output | 5 | Multiplication factor in use |
| resetReq | output | 1 | Sticky reset request on loss of clock |
| sysClk | output | 1 | Divided system clock |
| clkOut | output | 1 | Gated system clock output pin |

## Verification
A post-divider change and a lock drop caused by a multiplier write can land on the same clock edge. The bench provokes this with a single write that changes both fields while the block is locked. At that edge the old request is staged, and the new post-divider code must then wait out the whole relock window. The bench judges the outcome in two places. It first checks that `lockOut` is low right after the write. It then checks that the final `sysClk` period matches the new code, and runt detection stays active across every divider switch in the full 8x8 code sweep.

// File: rtl/clksyn_pkg.sv
`timescale 1ns/1ps
package clksyn_pkg;
  localparam int CODE_W = 3;
  localparam int MF_W = 5;
  localparam int POS_DIV = 0;
  localparam int POS_MULT = POS_DIV + CODE_W;
  localparam int POS_LOCEN = POS_MULT + CODE_W;
  localparam int POS_LOCRST = POS_LOCEN + 1;
  localparam int POS_OFF = POS_LOCRST + 1;
  localparam int REG_W = POS_OFF + 1;
  localparam logic [CODE_W-1:0] DIV_RST = 3'd1;
  localparam logic [CODE_W-1:0] MULT_RST = 3'd2;

  typedef struct packed {
    logic [CODE_W-1:0] divTarget;
    logic outOff;
  } divCtrl_t;
endpackage

// File: rtl/clksyn_ctrl.sv
`timescale 1ns/1ps
module clksyn_ctrl
  import clksyn_pkg::*;
#(
  parameter int RELOCK_CYCLES = 16
) (
  input  logic             pllClk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             extClkMode,
  input  logic             oneToOneMode,
  input  logic             pllLockIn,
  input  logic             pllStopOff,
  input  logic             locStatus,
  output logic [REG_W-1:0] rdData,
  output logic             lockOut,
  output logic [MF_W-1:0]  multFactor,
  output logic             resetReq,
  output divCtrl_t         divCtl
);
  localparam int RL_W = $clog2(RELOCK_CYCLES + 1);

  logic [CODE_W-1:0] divReq;
  logic [CODE_W-1:0] multCode;
  logic [CODE_W-1:0] divStaged;
  logic              locEnQ;
  logic              locRstQ;
  logic              outOffQ;
  logic [RL_W-1:0]   relockCnt;
  logic              multChange;
  logic              lockQual;
  logic              locTrip;
  logic              multBypass;

  assign multBypass = extClkMode || oneToOneMode;
  assign multChange = wrEn && !multBypass &&
                      (wrData[POS_MULT +: CODE_W] != multCode);
  assign lockQual   = pllLockIn && !pllStopOff && (relockCnt == '0);
  assign locTrip    = locEnQ && locRstQ && locStatus && !extClkMode;

  // Register fields
  always_ff @(posedge pllClk or negedge rstN) begin
    if (!rstN) begin
      divReq   <= DIV_RST;
      multCode <= MULT_RST;
      locEnQ   <= 1'b0;
      locRstQ  <= 1'b0;
      outOffQ  <= 1'b0;
    end else if (wrEn) begin
      divReq   <= wrData[POS_DIV +: CODE_W];
      multCode <= wrData[POS_MULT +: CODE_W];
      locEnQ   <= wrData[POS_LOCEN];
      locRstQ  <= wrData[POS_LOCRST];
      outOffQ  <= wrData[POS_OFF];
    end
  end

  // Relock window after a multiplier change or a PLL stop
  always_ff @(posedge pllClk or negedge rstN) begin
    if (!rstN) begin
      relockCnt <= '0;
    end else if (multChange || pllStopOff) begin
      relockCnt <= RL_W'(RELOCK_CYCLES);
    end else if (relockCnt != '0) begin
      relockCnt <= relockCnt - 1'b1;
    end
  end

  // Post-divider staging, only while locked
  always_ff @(posedge pllClk or negedge rstN) begin
    if (!rstN) begin
      divStaged <= DIV_RST;
    end else if (lockQual) begin
      divStaged <= divReq;
    end
  end

  // Sticky reset request
  always_ff @(posedge pllClk or negedge rstN) begin
    if (!rstN) begin
      resetReq <= 1'b0;
    end else if (locTrip) begin
      resetReq <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[POS_DIV +: CODE_W]  = divReq;
    rdData[POS_MULT +: CODE_W] = multCode;
    rdData[POS_LOCEN]          = locEnQ;
    rdData[POS_LOCRST]         = locRstQ;
    rdData[POS_OFF]            = outOffQ;
  end

  always_comb begin
    if (multBypass) begin
      multFactor = MF_W'(1);
    end else begin
      multFactor = MF_W'({multCode, 1'b0}) + MF_W'(4);
    end
  end

  assign lockOut          = lockQual;
  assign divCtl.divTarget = divStaged;
  assign divCtl.outOff    = outOffQ;
endmodule

// File: rtl/clksyn_divpath.sv
`timescale 1ns/1ps
module clksyn_divpath
  import clksyn_pkg::*;
(
  input  logic     pllClk,
  input  logic     rstN,
  input  divCtrl_t divCtl,
  output logic     sysClk,
  output logic     clkOut
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0]  divCnt;
  logic [CNT_W-1:0]  lowMask;
  logic [CODE_W-1:0] activeCode;
  logic              bypass;
  logic              fallNow;
  logic              armNow;
  logic              armQ;
  logic              tapBit;

  assign bypass = (activeCode == '0);

  // Bits below the tap: all ones means the tap falls on this edge
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign lowMask[i] = (int'(activeCode) > i);
  end

  assign fallNow = !bypass && ((divCnt & lowMask) == lowMask);
  assign armNow  = fallNow && (divCtl.divTarget != activeCode);

  always_ff @(posedge pllClk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      armQ   <= 1'b0;
    end else begin
      armQ <= armNow;
      if (bypass || armNow) begin
        divCnt <= '0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // Code hand-off on the falling PLL edge, while the system clock is low
  always_ff @(negedge pllClk or negedge rstN) begin
    if (!rstN) begin
      activeCode <= DIV_RST;
    end else if (armQ || (bypass && (divCtl.divTarget != activeCode))) begin
      activeCode <= divCtl.divTarget;
    end
  end

  always_comb begin
    tapBit = 1'b0;
    for (int i = 0; i < CNT_W; i++) begin
      if (int'(activeCode) == i + 1) begin
        tapBit = divCnt[i];
      end
    end
  end

  assign sysClk = bypass ? pllClk : tapBit;
  assign clkOut = sysClk & !divCtl.outOff;
endmodule

// File: rtl/clksyn_postdiv.sv
`timescale 1ns/1ps
module clksyn_postdiv
  import clksyn_pkg::*;
#(
  parameter int RELOCK_CYCLES = 16
) (
  input  logic             pllClk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             extClkMode,
  input  logic             oneToOneMode,
  input  logic             pllLockIn,
  input  logic             pllStopOff,
  input  logic             locStatus,
  output logic             lockOut,
  output logic [MF_W-1:0]  multFactor,
  output logic             resetReq,
  output logic             sysClk,
  output logic             clkOut
);
  divCtrl_t divCtl;

  clksyn_ctrl #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_ctrl (
    .pllClk      (pllClk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .extClkMode  (extClkMode),
    .oneToOneMode(oneToOneMode),
    .pllLockIn   (pllLockIn),
    .pllStopOff  (pllStopOff),
    .locStatus   (locStatus),
    .rdData      (rdData),
    .lockOut     (lockOut),
    .multFactor  (multFactor),
    .resetReq    (resetReq),
    .divCtl      (divCtl)
  );

  clksyn_divpath u_div (
    .pllClk(pllClk),
    .rstN  (rstN),
    .divCtl(divCtl),
    .sysClk(sysClk),
    .clkOut(clkOut)
  );
endmodule

// File: rtl/clksyn_postdiv_chk.sv
`timescale 1ns/1ps
module clksyn_postdiv_chk
  import clksyn_pkg::*;
(
  input logic              pllClk,
  input logic              rstN,
  input logic              wrEn,
  input logic [CODE_W-1:0] wrMult,
  input logic [CODE_W-1:0] rdMult,
  input logic              rdLocEn,
  input logic              rdLocRst,
  input logic              rdOff,
  input logic              extClkMode,
  input logic              oneToOneMode,
  input logic              pllLockIn,
  input logic              pllStopOff,
  input logic              locStatus,
  input logic              lockOut,
  input logic [MF_W-1:0]   multFactor,
  input logic              resetReq,
  input logic              clkOut
);
  assert_lock_drop_R4: assert property (@(posedge pllClk) disable iff (!rstN)
    (wrEn && !extClkMode && !oneToOneMode && (wrMult != rdMult)) |=> !lockOut);

  assert_mult_ignored_R6: assert property (@(posedge pllClk) disable iff (!rstN)
    (wrEn && (extClkMode || oneToOneMode) && lockOut)
      |=> (lockOut || !pllLockIn || pllStopOff));

  assert_mult_factor_R5: assert property (@(posedge pllClk) disable iff (!rstN)
    (extClkMode || oneToOneMode) |-> (multFactor == MF_W'(1)));

  assert_mult_even_R5: assert property (@(posedge pllClk) disable iff (!rstN)
    (!extClkMode && !oneToOneMode) |->
      (multFactor[0] == 1'b0 && multFactor >= MF_W'(4) && multFactor <= MF_W'(18)));

  assert_stop_unlock_R8: assert property (@(posedge pllClk) disable iff (!rstN)
    pllStopOff |-> !lockOut);

  assert_reset_sticky_R9: assert property (@(posedge pllClk) disable iff (!rstN)
    resetReq |=> resetReq);

  assert_reset_cause_R9: assert property (@(posedge pllClk) disable iff (!rstN)
    $rose(resetReq) |-> $past(rdLocEn && rdLocRst && locStatus && !extClkMode));

  assert_clkout_off_R10: assert property (@(posedge pllClk) disable iff (!rstN)
    (rdOff && $past(rdOff)) |-> !clkOut);
endmodule

bind clksyn_postdiv clksyn_postdiv_chk u_chk (
  .pllClk      (pllClk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrMult      (wrData[clksyn_pkg::POS_MULT +: clksyn_pkg::CODE_W]),
  .rdMult      (rdData[clksyn_pkg::POS_MULT +: clksyn_pkg::CODE_W]),
  .rdLocEn     (rdData[clksyn_pkg::POS_LOCEN]),
  .rdLocRst    (rdData[clksyn_pkg::POS_LOCRST]),
  .rdOff       (rdData[clksyn_pkg::POS_OFF]),
  .extClkMode  (extClkMode),
  .oneToOneMode(oneToOneMode),
  .pllLockIn   (pllLockIn),
  .pllStopOff  (pllStopOff),
  .locStatus   (locStatus),
  .lockOut     (lockOut),
  .multFactor  (multFactor),
  .resetReq    (resetReq),
  .clkOut      (clkOut)
);

// File: tb/clksyn_postdiv_tb.sv
`timescale 1ns/1ps
module clksyn_postdiv_tb;
  localparam int RL = 16;

  logic       pllClk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic [8:0] rdData;
  logic       extClkMode = 1'b0;
  logic       oneToOneMode = 1'b0;
  logic       pllLockIn = 1'b1;
  logic       pllStopOff = 1'b0;
  logic       locStatus = 1'b0;
  logic       lockOut;
  logic [4:0] multFactor;
  logic       resetReq;
  logic       sysClk;
  logic       clkOut;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  real tRise = -1.0;
  real tFall = -1.0;
  real minHigh = 1.0e9;
  real minLow = 1.0e9;

  always #2.5 pllClk = ~pllClk;

  clksyn_postdiv #(.RELOCK_CYCLES(RL)) u_dut (
    .pllClk(pllClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .extClkMode(extClkMode), .oneToOneMode(oneToOneMode), .pllLockIn(pllLockIn),
    .pllStopOff(pllStopOff), .locStatus(locStatus), .lockOut(lockOut),
    .multFactor(multFactor), .resetReq(resetReq), .sysClk(sysClk), .clkOut(clkOut)
  );

  always @(posedge sysClk) begin
    if (tFall >= 0.0 && ($realtime - tFall) < minLow) minLow = $realtime - tFall;
    tRise = $realtime;
  end

  always @(negedge sysClk) begin
    if (tRise >= 0.0 && ($realtime - tRise) < minHigh) minHigh = $realtime - tRise;
    tFall = $realtime;
  end

  function automatic logic [8:0] mk(input bit off, input bit lre, input bit le,
                                    input logic [2:0] mult, input logic [2:0] dv);
    return {off, lre, le, mult, dv};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [8:0] v);
    @(negedge pllClk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge pllClk);
    wrEn = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge pllClk);
    @(negedge pllClk);
  endtask

  task automatic measure(output longint ps);
    real t0;
    @(posedge sysClk);
    t0 = $realtime;
    @(posedge sysClk);
    ps = longint'(($realtime - t0) * 1000.0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    longint per;
    bit seen;
    repeat (4) @(negedge pllClk);
    rstN = 1'b1;
    @(negedge pllClk);

    // R1 reset state
    check(rdData == 9'h011, "R1 rdData", rdData, 9'h011);
    check(lockOut == 1'b1, "R1 lockOut", lockOut, 1);
    check(resetReq == 1'b0, "R1 resetReq", resetReq, 0);
    measure(per);
    check(per == 10000, "R1 period", per, 10000);

    // R4 multiplier change opens relock window
    writeReg(mk(0, 0, 0, 3'd5, 3'd1));
    check(lockOut == 1'b0, "R4 drop", lockOut, 0);
    repeat (RL - 1) @(posedge pllClk);
    @(negedge pllClk);
    check(lockOut == 1'b0, "R4 window end-1", lockOut, 0);
    @(posedge pllClk);
    @(negedge pllClk);
    check(lockOut == 1'b1, "R4 relock", lockOut, 1);
    check(rdData == mk(0, 0, 0, 3'd5, 3'd1), "R11 readback", rdData, mk(0, 0, 0, 3'd5, 3'd1));
    writeReg(mk(0, 0, 0, 3'd5, 3'd1));
    check(lockOut == 1'b1, "R4 same value keeps lock", lockOut, 1);

    // R5 multiplication factor
    for (int m = 0; m < 8; m++) begin
      writeReg(mk(0, 0, 0, 3'(m), 3'd1));
      check(multFactor == 5'(2 * (m + 2)), "R5 factor", multFactor, 2 * (m + 2));
    end
    oneToOneMode = 1'b1;
    @(negedge pllClk);
    check(multFactor == 5'd1, "R5 one-to-one", multFactor, 1);
    oneToOneMode = 1'b0;
    extClkMode = 1'b1;
    @(negedge pllClk);
    check(multFactor == 5'd1, "R5 external", multFactor, 1);
    extClkMode = 1'b0;
    waitCyc(RL + 2);

    // R6 multiplier ignored in bypass modes
    oneToOneMode = 1'b1;
    writeReg(mk(0, 0, 0, 3'd0, 3'd1));
    check(lockOut == 1'b1, "R6 one-to-one", lockOut, 1);
    oneToOneMode = 1'b0;
    extClkMode = 1'b1;
    writeReg(mk(0, 0, 0, 3'd6, 3'd1));
    check(lockOut == 1'b1, "R6 external", lockOut, 1);
    extClkMode = 1'b0;

    // R8 stop mode
    @(negedge pllClk);
    pllStopOff = 1'b1;
    @(negedge pllClk);
    check(lockOut == 1'b0, "R8 stopped", lockOut, 0);
    pllStopOff = 1'b0;
    repeat (RL - 1) @(posedge pllClk);
    @(negedge pllClk);
    check(lockOut == 1'b0, "R8 window", lockOut, 0);
    @(posedge pllClk);
    @(negedge pllClk);
    check(lockOut == 1'b1, "R8 relock", lockOut, 1);

    // R2 and R3: all code-to-code switches
    for (int f = 0; f < 8; f++) begin
      for (int t = 0; t < 8; t++) begin
        writeReg(mk(0, 0, 0, 3'd6, 3'(f)));
        waitCyc(300);
        minHigh = 1.0e9;
        minLow = 1.0e9;
        writeReg(mk(0, 0, 0, 3'd6, 3'(t)));
        waitCyc(300);
        measure(per);
        check(per == 5000 * (longint'(1) << t), "R2 period", per, 5000 * (longint'(1) << t));
        check(minHigh >= 2.49 && minLow >= 2.49, "R3 runt ps",
              longint'((minHigh < minLow ? minHigh : minLow) * 1000.0), 2500);
      end
    end

    // R7 pending while unlocked
    writeReg(mk(0, 0, 0, 3'd6, 3'd1));
    waitCyc(300);
    pllLockIn = 1'b0;
    writeReg(mk(0, 0, 0, 3'd6, 3'd3));
    waitCyc(300);
    measure(per);
    check(per == 10000, "R7 held", per, 10000);
    check(rdData[2:0] == 3'd3, "R11 pending code", rdData[2:0], 3);
    pllLockIn = 1'b1;
    waitCyc(300);
    measure(per);
    check(per == 40000, "R7 applied", per, 40000);

    // R7 with R4 on the same edge
    writeReg(mk(0, 0, 0, 3'd2, 3'd0));
    check(lockOut == 1'b0, "R4 combined drop", lockOut, 0);
    waitCyc(300);
    measure(per);
    check(per == 5000, "R7 combined", per, 5000);

    // R10 output gating
    writeReg(mk(1, 0, 0, 3'd2, 3'd1));
    waitCyc(4);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(pllClk);
      #1;
      if (clkOut) seen = 1'b1;
    end
    check(seen == 1'b0, "R10 held low", seen, 0);
    writeReg(mk(0, 0, 0, 3'd2, 3'd1));
    waitCyc(4);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(pllClk);
      #1;
      if (clkOut) seen = 1'b1;
    end
    check(seen == 1'b1, "R10 toggles", seen, 1);

    // R9 reset request gating
    writeReg(mk(0, 1, 0, 3'd2, 3'd1));
    locStatus = 1'b1;
    waitCyc(4);
    check(resetReq == 1'b0, "R9 enable clear", resetReq, 0);
    extClkMode = 1'b1;
    writeReg(mk(0, 1, 1, 3'd2, 3'd1));
    waitCyc(4);
    check(resetReq == 1'b0, "R9 external mode", resetReq, 0);
    extClkMode = 1'b0;
    @(posedge pllClk);
    @(negedge pllClk);
    check(resetReq == 1'b1, "R9 request", resetReq, 1);
    locStatus = 1'b0;
    waitCyc(3);
    check(resetReq == 1'b1, "R9 sticky", resetReq, 1);
    rstN = 1'b0;
    @(negedge pllClk);
    check(resetReq == 1'b0, "R9 cleared", resetReq, 0);
    check(rdData == 9'h011, "R1 re-reset", rdData, 9'h011);
    rstN = 1'b1;
    waitCyc(2);

    finishRun();
  end
endmodule